// File: doc/BRIEF.md
# Seeded Cross-Pattern Motion Vector Refiner

This block picks a search centre for one 16x16 macroblock while a compressed stream is re-encoded, and then improves that centre by a single integer-pixel step. It receives two candidate seeds. The first is the motion vector carried over from the incoming stream. The second is a predictor built from already-coded neighbouring blocks, together with a flag that says whether that predictor exists. The block has no cost arithmetic of its own. It hands each candidate vector to an external cost evaluator through a valid/ready handshake and takes back one cost per candidate.

A run starts with a one-cycle `start` pulse. The block first costs the carried-over vector. If the neighbour predictor is valid, it costs that vector next. The cheaper of the two becomes the centre. When the predictor is missing, for example at a picture edge, the carried-over vector is the centre. The block then costs the four positions one pixel up, down, left and right of the centre. The cheapest of the five positions is reported with its cost on a one-cycle `done` strobe. Before any candidate is issued, each vector component is clamped into a symmetric, configurable range.

Top module: `mv_refine_top`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low, and the seed inputs are captured at that edge. `busy` is high from the next cycle until the cycle after `done`. A `start` pulse or changed inputs during a run have no effect on that run.
- R2: The first candidate of every run is the carried-over vector (`inc_x`, `inc_y`) after clamping.
- R3: When `pred_ok` is 1, the second candidate is the neighbour predictor after clamping, and the run issues 6 candidates in total. The centre is the cheaper of the first two. On equal cost the carried-over vector is the centre.
- R4: When `pred_ok` is 0, no predictor candidate is issued. The carried-over vector is the centre and the run issues 5 candidates in total.
- R5: After the centre is chosen, four candidates follow in this order: (cx, cy-1) up, (cx, cy+1) down, (cx-1, cy) left, (cx+1, cy) right. Negative y means up.
- R6: Every issued component is clamped into [-MV_LIM, +MV_LIM] before it is issued. Components are signed 8-bit integer-pixel values. Costs are 16-bit unsigned.
- R7: The result is the minimum-cost position among the centre and its four neighbours. On equal cost the earlier position wins, in the order centre, up, down, left, right.
- R8: A candidate stays unchanged while `cand_valid` is high and `cand_ready` is low. Only one candidate is outstanding at a time. A cost is taken from `cost_valid`/`cost_in` only after its candidate has been accepted.
- R9: `done` is high for exactly one cycle, with `best_x`, `best_y` and `best_cost` valid in that cycle and `cand_valid` low.
- R10: While `rst` is high and after its release, `busy`, `cand_valid` and `done` are 0. A reset in the middle of a run abandons the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a refinement run |
| inc_x | input | 8 | Carried-over vector, horizontal (signed) |
| inc_y | input | 8 | Carried-over vector, vertical (signed) |
| pred_x | input | 8 | Neighbour predictor, horizontal (signed) |
| pred_y | input | 8 | Neighbour predictor, vertical (signed) |
| pred_ok | input | 1 | Neighbour predictor is available |
| busy | output | 1 | Run in progress |
| cand_valid | output | 1 | Candidate vector offered to the evaluator |
| cand_ready | input | 1 | Evaluator accepts the candidate |
| cand_x | output | 8 | Candidate horizontal component (signed) |
| cand_y | output | 8 | Candidate vertical component (signed) |
| cost_valid | input | 1 | Cost for the accepted candidate is present |
| cost_in | input | 16 | Cost of the accepted candidate |
| done | output | 1 | One-cycle result strobe |
| best_x | output | 8 | Refined vector, horizontal (signed) |
| best_y | output | 8 | Refined vector, vertical (signed) |
| best_cost | output | 16 | Cost of the refined vector |

## Verification
The bench builds the block with MV_LIM set to 16 instead of the default 64. With that limit, seeds at the 8-bit extremes and neighbours one step outside the range are clamped, and a clamped neighbour that lands back on the centre exercises the keep-earlier tie rule. The evaluator model varies its acceptance stall and its cost latency from zero to two cycles between runs, so candidate hold under backpressure and cost arrival at different distances from acceptance are both covered.

// File: rtl/mvr_pkg.sv
package mvr_pkg;

    localparam int MV_W   = 8;
    localparam int COST_W = 16;

    typedef logic signed [MV_W-1:0] mv_comp_t;
    typedef logic signed [MV_W:0]   mv_wide_t;
    typedef logic [COST_W-1:0]      cost_t;

    typedef struct packed {
        mv_comp_t x;
        mv_comp_t y;
    } mv_t;

    // candidate slot within one run, in issue order
    typedef enum logic [2:0] {
        PH_INC  = 3'd0,
        PH_PRED = 3'd1,
        PH_UP   = 3'd2,
        PH_DN   = 3'd3,
        PH_LT   = 3'd4,
        PH_RT   = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SEED  = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

    function automatic mv_wide_t widen(input mv_comp_t c);
        return {c[MV_W-1], c};
    endfunction

    function automatic mv_comp_t clamp_comp(input mv_wide_t v, input mv_wide_t lim);
        mv_wide_t neg_lim;
        mv_wide_t res;
        neg_lim = -lim;
        if (v > lim)
            res = lim;
        else if (v < neg_lim)
            res = neg_lim;
        else
            res = v;
        return res[MV_W-1:0];
    endfunction

    function automatic mv_t clamp_mv(input mv_wide_t vx, input mv_wide_t vy,
                                     input mv_wide_t lim);
        mv_t r;
        r.x = clamp_comp(vx, lim);
        r.y = clamp_comp(vy, lim);
        return r;
    endfunction

endpackage

// File: rtl/mvr_cand_gen.sv
module mvr_cand_gen
    import mvr_pkg::*;
#(
    parameter int MV_LIM = 64
) (
    input  phase_e phase,
    input  mv_t    inc_mv,
    input  mv_t    pred_mv,
    input  mv_t    centre_mv,
    output mv_t    cand_mv
);

    localparam mv_wide_t LIM = mv_wide_t'(MV_LIM);

    mv_wide_t raw_x;
    mv_wide_t raw_y;
    mv_wide_t cx;
    mv_wide_t cy;

    assign cx = widen(centre_mv.x);
    assign cy = widen(centre_mv.y);

    always_comb begin
        unique case (phase)
            PH_INC: begin
                raw_x = widen(inc_mv.x);
                raw_y = widen(inc_mv.y);
            end
            PH_PRED: begin
                raw_x = widen(pred_mv.x);
                raw_y = widen(pred_mv.y);
            end
            PH_UP: begin
                raw_x = cx;
                raw_y = cy - mv_wide_t'(1);
            end
            PH_DN: begin
                raw_x = cx;
                raw_y = cy + mv_wide_t'(1);
            end
            PH_LT: begin
                raw_x = cx - mv_wide_t'(1);
                raw_y = cy;
            end
            PH_RT: begin
                raw_x = cx + mv_wide_t'(1);
                raw_y = cy;
            end
            default: begin
                raw_x = cx;
                raw_y = cy;
            end
        endcase
    end

    assign cand_mv = clamp_mv(raw_x, raw_y, LIM);

endmodule

// File: rtl/mvr_best_track.sv
module mvr_best_track
    import mvr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  offer,
    input  mv_t   cand_mv,
    input  cost_t cand_cost,
    output mv_t   best_mv,
    output cost_t best_cost
);

    logic better;

    // strictly lower only: an equal cost keeps the earlier holder
    assign better = offer && (cand_cost < best_cost);

    always_ff @(posedge clk) begin
        if (rst) begin
            best_mv   <= '0;
            best_cost <= '0;
        end else if (load || better) begin
            best_mv   <= cand_mv;
            best_cost <= cand_cost;
        end
    end

endmodule

// File: rtl/mvr_ctrl.sv
module mvr_ctrl
    import mvr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   pred_ok,
    input  logic   cand_ready,
    input  logic   cost_valid,
    output phase_e phase,
    output logic   capture,
    output logic   cand_valid,
    output logic   load,
    output logic   offer,
    output logic   seed_en,
    output logic   busy,
    output logic   done
);

    state_e state;
    state_e state_nx;
    phase_e phase_nx;
    logic   cost_take;

    assign capture    = start && (state == ST_IDLE);
    assign cand_valid = (state == ST_ISSUE);
    assign cost_take  = (state == ST_WAIT) && cost_valid;
    assign load       = cost_take && (phase == PH_INC);
    assign offer      = cost_take && (phase != PH_INC);
    assign seed_en    = (state == ST_SEED);
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);

    always_comb begin
        state_nx = state;
        phase_nx = phase;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_ISSUE;
                    phase_nx = PH_INC;
                end
            end
            ST_ISSUE: begin
                if (cand_ready)
                    state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (cost_valid) begin
                    unique case (phase)
                        PH_INC: begin
                            if (pred_ok) begin
                                phase_nx = PH_PRED;
                                state_nx = ST_ISSUE;
                            end else begin
                                state_nx = ST_SEED;
                            end
                        end
                        PH_PRED: state_nx = ST_SEED;
                        PH_UP: begin
                            phase_nx = PH_DN;
                            state_nx = ST_ISSUE;
                        end
                        PH_DN: begin
                            phase_nx = PH_LT;
                            state_nx = ST_ISSUE;
                        end
                        PH_LT: begin
                            phase_nx = PH_RT;
                            state_nx = ST_ISSUE;
                        end
                        default: state_nx = ST_DONE;
                    endcase
                end
            end
            ST_SEED: begin
                phase_nx = PH_UP;
                state_nx = ST_ISSUE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_INC;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

endmodule

// File: rtl/mv_refine_top.sv
module mv_refine_top
    import mvr_pkg::*;
#(
    parameter int MV_LIM = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [MV_W-1:0]  inc_x,
    input  logic signed [MV_W-1:0]  inc_y,
    input  logic signed [MV_W-1:0]  pred_x,
    input  logic signed [MV_W-1:0]  pred_y,
    input  logic                    pred_ok,
    output logic                    busy,
    output logic                    cand_valid,
    input  logic                    cand_ready,
    output logic signed [MV_W-1:0]  cand_x,
    output logic signed [MV_W-1:0]  cand_y,
    input  logic                    cost_valid,
    input  logic [COST_W-1:0]       cost_in,
    output logic                    done,
    output logic signed [MV_W-1:0]  best_x,
    output logic signed [MV_W-1:0]  best_y,
    output logic [COST_W-1:0]       best_cost
);

    phase_e phase;
    logic   capture;
    logic   load;
    logic   offer;
    logic   seed_en;
    logic   ok_q;
    mv_t    inc_q;
    mv_t    pred_q;
    mv_t    centre_q;
    mv_t    cand_mv;
    mv_t    best_mv;
    cost_t  best_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q  <= '0;
            pred_q <= '0;
            ok_q   <= 1'b0;
        end else if (capture) begin
            inc_q  <= '{x: inc_x,  y: inc_y};
            pred_q <= '{x: pred_x, y: pred_y};
            ok_q   <= pred_ok;
        end
    end

    // the winner of the seed comparison becomes the cross centre
    always_ff @(posedge clk) begin
        if (rst)
            centre_q <= '0;
        else if (seed_en)
            centre_q <= best_mv;
    end

    mvr_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pred_ok    (ok_q),
        .cand_ready (cand_ready),
        .cost_valid (cost_valid),
        .phase      (phase),
        .capture    (capture),
        .cand_valid (cand_valid),
        .load       (load),
        .offer      (offer),
        .seed_en    (seed_en),
        .busy       (busy),
        .done       (done)
    );

    mvr_cand_gen #(
        .MV_LIM (MV_LIM)
    ) u_gen (
        .phase     (phase),
        .inc_mv    (inc_q),
        .pred_mv   (pred_q),
        .centre_mv (centre_q),
        .cand_mv   (cand_mv)
    );

    mvr_best_track u_best (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .offer     (offer),
        .cand_mv   (cand_mv),
        .cand_cost (cost_in),
        .best_mv   (best_mv),
        .best_cost (best_c)
    );

    assign cand_x    = cand_mv.x;
    assign cand_y    = cand_mv.y;
    assign best_x    = best_mv.x;
    assign best_y    = best_mv.y;
    assign best_cost = best_c;

endmodule

// File: rtl/mv_refine_chk.sv
module mv_refine_chk
    import mvr_pkg::*;
#(
    parameter int MV_LIM = 64
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   busy,
    input logic                   cand_valid,
    input logic                   cand_ready,
    input logic signed [MV_W-1:0] cand_x,
    input logic signed [MV_W-1:0] cand_y,
    input logic                   done
);

    // R8
    cand_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_x) && $stable(cand_y)));

    // R6
    cand_range_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (int'(cand_x) <= MV_LIM && int'(cand_x) >= -MV_LIM &&
                        int'(cand_y) <= MV_LIM && int'(cand_y) >= -MV_LIM));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cand_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cand_valid && !done));

    // R8
    accept_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && cand_ready) |=> !cand_valid);

endmodule

bind mv_refine_top mv_refine_chk #(.MV_LIM(MV_LIM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cand_valid (cand_valid),
    .cand_ready (cand_ready),
    .cand_x     (cand_x),
    .cand_y     (cand_y),
    .done       (done)
);

// File: tb/mv_refine_top_tb_top.sv
module mv_refine_top_tb_top;

    localparam int LIM   = 16;
    localparam int NVEC  = 8;
    localparam int NFLD  = 12;
    // fields: inc x,y | pred x,y | ok | target x,y | centre x,y | best x,y | best cost
    localparam int VEC [NVEC][NFLD] = '{
        '{   2,   3,    5,  5, 1,   6,   5,    5,   5,    6,   5,  10},
        '{  -3,   0,    9,  9, 0,  -3,   1,   -3,   0,   -3,   1,  10},
        '{   0,   0,    2,  0, 1,   1,   0,    0,   0,    1,   0,  10},
        '{   4,   4,    0,  0, 1,   4,   4,    4,   4,    4,   4,  10},
        '{  20, -30,    0,  0, 0,  16, -16,   16, -16,   16, -16,  10},
        '{  10,  10,    0,  0, 1,  -1,  -1,    0,   0,    0,  -1,  14},
        '{   0,   3, -100,  3, 1, -15,   3,  -16,   3,  -15,   3,  10},
        '{-128, 127,    0,  0, 0,   0,   0,  -16,  16,  -16,  15, 134}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic signed [7:0] inc_x = '0;
    logic signed [7:0] inc_y = '0;
    logic signed [7:0] pred_x = '0;
    logic signed [7:0] pred_y = '0;
    logic              pred_ok = 1'b0;
    logic              busy;
    logic              cand_valid;
    logic              cand_ready = 1'b0;
    logic signed [7:0] cand_x;
    logic signed [7:0] cand_y;
    logic              cost_valid = 1'b0;
    logic [15:0]       cost_in = '0;
    logic              done;
    logic signed [7:0] best_x;
    logic signed [7:0] best_y;
    logic [15:0]       best_cost;

    int checks = 0;
    int errors = 0;

    int lg_x [8];
    int lg_y [8];
    int lg_n = 0;
    int tgt_x = 0;
    int tgt_y = 0;
    int stall_cfg = 0;
    int stall_cnt = 0;
    int lat = 0;
    int first_x = 0;
    int first_y = 0;
    bit seen = 1'b0;
    bit pend = 1'b0;
    int pend_cost = 0;

    always #4 clk = ~clk;

    mv_refine_top #(.MV_LIM(LIM)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .inc_x      (inc_x),
        .inc_y      (inc_y),
        .pred_x     (pred_x),
        .pred_y     (pred_y),
        .pred_ok    (pred_ok),
        .busy       (busy),
        .cand_valid (cand_valid),
        .cand_ready (cand_ready),
        .cand_x     (cand_x),
        .cand_y     (cand_y),
        .cost_valid (cost_valid),
        .cost_in    (cost_in),
        .done       (done),
        .best_x     (best_x),
        .best_y     (best_y),
        .best_cost  (best_cost)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int clampi(input int v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic int cost_of(input int x, input int y, input int tx, input int ty);
        return 4 * iabs(x - tx) + 4 * iabs(y - ty) + 10;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // cost evaluator model: stalls acceptance, then answers after a latency
    always @(negedge clk) begin
        if (rst) begin
            cand_ready = 1'b0;
            cost_valid = 1'b0;
            pend       = 1'b0;
            seen       = 1'b0;
            stall_cnt  = 0;
        end else begin
            cost_valid = 1'b0;
            if (cand_ready) begin
                cand_ready = 1'b0;
                pend       = 1'b1;
                lat        = stall_cfg;
            end else if (pend) begin
                if (lat == 0) begin
                    cost_valid = 1'b1;
                    cost_in    = 16'(pend_cost);
                    pend       = 1'b0;
                end else begin
                    lat--;
                end
            end else if (cand_valid) begin
                if (!seen) begin
                    seen      = 1'b1;
                    first_x   = int'(cand_x);
                    first_y   = int'(cand_y);
                    stall_cnt = 0;
                end
                if (stall_cnt >= stall_cfg) begin
                    // R8 candidate unchanged through the stall
                    check(int'(cand_x) == first_x && int'(cand_y) == first_y,
                          "R8", "candidate held", int'(cand_x), first_x);
                    if (lg_n < 8) begin
                        lg_x[lg_n] = int'(cand_x);
                        lg_y[lg_n] = int'(cand_y);
                    end
                    lg_n++;
                    pend_cost  = cost_of(int'(cand_x), int'(cand_y), tgt_x, tgt_y);
                    cand_ready = 1'b1;
                    seen       = 1'b0;
                end else begin
                    stall_cnt++;
                end
            end
        end
    end

    task automatic drive_seed(input int idx);
        inc_x   = 8'(VEC[idx][0]);
        inc_y   = 8'(VEC[idx][1]);
        pred_x  = 8'(VEC[idx][2]);
        pred_y  = 8'(VEC[idx][3]);
        pred_ok = VEC[idx][4] != 0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_run(input int idx, input bit got);
        int ncand;
        int base;
        int cx;
        int cy;
        check(got, "R9", "done seen", int'(got), 1);
        ncand = (VEC[idx][4] != 0) ? 6 : 5;
        check(lg_n == ncand, (ncand == 6) ? "R3" : "R4", "candidate count", lg_n, ncand);
        if (lg_n == ncand) begin
            // R2 R6 first candidate is clamped incoming vector
            check(lg_x[0] == clampi(VEC[idx][0]) && lg_y[0] == clampi(VEC[idx][1]),
                  "R2", "first candidate x", lg_x[0], clampi(VEC[idx][0]));
            if (ncand == 6)
                check(lg_x[1] == clampi(VEC[idx][2]) && lg_y[1] == clampi(VEC[idx][3]),
                      "R3", "predictor candidate x", lg_x[1], clampi(VEC[idx][2]));
            base = ncand - 4;
            cx = VEC[idx][7];
            cy = VEC[idx][8];
            // R5 R6 cross order up, down, left, right with clamping
            check(lg_x[base] == cx && lg_y[base] == clampi(cy - 1),
                  "R5", "up candidate y", lg_y[base], clampi(cy - 1));
            check(lg_x[base+1] == cx && lg_y[base+1] == clampi(cy + 1),
                  "R5", "down candidate y", lg_y[base+1], clampi(cy + 1));
            check(lg_x[base+2] == clampi(cx - 1) && lg_y[base+2] == cy,
                  "R6", "left candidate x", lg_x[base+2], clampi(cx - 1));
            check(lg_x[base+3] == clampi(cx + 1) && lg_y[base+3] == cy,
                  "R6", "right candidate x", lg_x[base+3], clampi(cx + 1));
        end
        check(int'(best_x) == VEC[idx][9], "R7", "best x", int'(best_x), VEC[idx][9]);
        check(int'(best_y) == VEC[idx][10], "R7", "best y", int'(best_y), VEC[idx][10]);
        check(int'(best_cost) == VEC[idx][11], "R7", "best cost", int'(best_cost), VEC[idx][11]);
        check(!cand_valid, "R9", "cand_valid during done", int'(cand_valid), 0);
        @(negedge clk);
        check(!done, "R9", "done width", int'(done), 0);
        check(!busy, "R1", "busy after done", int'(busy), 0);
    endtask

    task automatic run_case(input int idx, input bit interfere);
        bit got;
        @(negedge clk);
        drive_seed(idx);
        tgt_x     = VEC[idx][5];
        tgt_y     = VEC[idx][6];
        stall_cfg = idx % 3;
        lg_n      = 0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R1", "busy after start", int'(busy), 1);
        if (interfere) begin
            @(negedge clk);
            @(negedge clk);
            drive_seed(7);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(got);
        check_run(idx, got);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 state while in reset
        check(!busy && !cand_valid && !done, "R10", "outputs in reset",
              int'(busy) + int'(cand_valid) + int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !cand_valid && !done, "R10", "outputs after reset",
              int'(busy) + int'(cand_valid) + int'(done), 0);

        for (int v = 0; v < NVEC; v++)
            run_case(v, 1'b0);

        // R1 start and new seeds during a run are ignored
        run_case(0, 1'b1);

        // R10 reset in the middle of a run abandons it
        @(negedge clk);
        drive_seed(1);
        tgt_x = VEC[1][5];
        tgt_y = VEC[1][6];
        stall_cfg = 1;
        lg_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !cand_valid, "R10", "idle after mid-run reset",
              int'(busy) + int'(cand_valid), 0);
        repeat (3) @(negedge clk);
        check(!done && !cand_valid, "R10", "no activity after abandon",
              int'(done) + int'(cand_valid), 0);

        // a run after the abandoned one still completes correctly
        run_case(5, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule